// File: doc/BRIEF.md
# Low-Side Overcurrent Trip Supervisor

This block watches the low-side switch of a synchronous buck power stage and shuts both gates off when the current through that switch stays too high. An external converter supplies millivolt codes. One code is a programming sample, taken once after power-on across a threshold-setting resistor. The other is the switch-node voltage, referred to ground, measured at the end of each low-side conduction interval and marked by a strobe.

After power-on reset, and once both supply rails are reported valid, a programming window opens. The first programming sample inside that window becomes the trip threshold. The value is capped at a ceiling, which is also the value used when the window closes with no sample. The threshold then stays locked until the next power-on reset. Disabling the regulator does not release it.

Each end-of-conduction strobe compares the sensed voltage with the locked threshold. A reading above the threshold advances a saturating counter. A reading at or below it sends the counter back to zero. When four readings in a row are above the threshold, a fault latches. The fault holds both gate enables low until power is cycled.

Top module: `lsw_ocp_guard`

## Requirements
- R1: After reset, `fault` is 0, `thr_locked` is 0, `thr_mv` is 0, and both gate enables are 0.
- R2: While `rails_ok` is 1 and the threshold is not yet locked, the first `prog_valid` locks `thr_mv` to min(`prog_mv`, 640). Any later `prog_valid` leaves `thr_mv` unchanged.
- R3: If `rails_ok` stays 1 for WIN_CYC (default 64) cycles and no `prog_valid` arrives, the threshold locks at 640. After that, `prog_valid` is ignored.
- R4: The locked threshold keeps its value while `reg_en` is 0 and after `reg_en` returns to 1.
- R5: A reading counts as over only when `ls_end` is 1 and `sense_mv` is strictly greater than `thr_mv`. A reading equal to the threshold does not count. A high `sense_mv` without `ls_end` does not count.
- R6: An `ls_end` reading that is not over resets the consecutive count to zero.
- R7: The fault sets on the clock edge that samples the fourth consecutive over reading, and `fault` reads 1 in the cycle after that edge. After three over readings it is still 0.
- R8: Once `fault` is 1 it stays 1, and `hs_en` and `ls_en` stay 0, until reset. Disable and clean readings do not change this.
- R9: `hs_en` equals `hs_req` and `ls_en` equals `ls_req` only while the threshold is locked, `reg_en` is 1 and there is no fault. In every other case both are 0.
- R10: `prog_valid` has no effect while `rails_ok` is 0.
- R11: An `ls_end` reading while `reg_en` is 0, or before the threshold is locked, does not advance the count. Driving `reg_en` to 0 clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| rails_ok | input | 1 | Both supply rails are above lockout |
| reg_en | input | 1 | Regulator enabled (0 means disabled) |
| prog_valid | input | 1 | Programming sample is valid |
| prog_mv | input | MV_W | Programming sample in mV |
| ls_end | input | 1 | Strobe at the end of low-side conduction |
| sense_mv | input | MV_W | Switch-node voltage in mV |
| hs_req | input | 1 | High-side gate request from the modulator |
| ls_req | input | 1 | Low-side gate request from the modulator |
| hs_en | output | 1 | Permitted high-side gate enable |
| ls_en | output | 1 | Permitted low-side gate enable |
| fault | output | 1 | Latched overcurrent fault |
| thr_locked | output | 1 | Threshold has been locked |
| thr_mv | output | MV_W | Locked trip threshold in mV |

## Verification
Programming is tried in four ways: a sample that arrives before the rails are valid, an in-range sample followed by a second one, an oversized sample, and no sample at all. Together these separate first-sample capture, clamping, and the fallback when the window expires.

The trip counter is driven with several reading patterns:
- readings exactly at the threshold, which exposes an off-by-one in the comparison;
- high voltage with no strobe, which shows that only strobed readings count;
- three over readings, one clean reading, then more over readings, which shows that the count restarts;
- a run of over readings broken by a disable, which shows that the disable clears the count.

Fault persistence and threshold retention are checked across disable toggles.

// File: rtl/lsw_ocp_pkg.sv
package lsw_ocp_pkg;
    localparam int unsigned MV_W_DEF    = 10;
    localparam int unsigned CEIL_MV_DEF = 640;
    localparam int unsigned TRIP_N_DEF  = 4;
    localparam int unsigned WIN_CYC_DEF = 64;

    typedef struct packed {
        logic       locked;
        logic [9:0] thr;
    } thr_view_t;
endpackage

// File: rtl/lsw_thr_lock.sv
module lsw_thr_lock #(
    parameter int unsigned MV_W    = 10,
    parameter int unsigned CEIL_MV = 640,
    parameter int unsigned WIN_CYC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rails_ok,
    input  logic            prog_valid,
    input  logic [MV_W-1:0] prog_mv,
    output logic            locked,
    output logic [MV_W-1:0] thr
);
    localparam int unsigned WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam logic [MV_W-1:0] CEIL = MV_W'(CEIL_MV);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

    typedef struct packed {
        logic             locked;
        logic [MV_W-1:0]  thr;
        logic [WIN_W-1:0] win;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.locked && rails_ok) begin
            if (prog_valid) begin
                st_d.thr    = (prog_mv > CEIL) ? CEIL : prog_mv;
                st_d.locked = 1'b1;
            end else if (st_q.win == WIN_LAST) begin
                st_d.thr    = CEIL;
                st_d.locked = 1'b1;
            end else begin
                st_d.win = st_q.win + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;
    assign thr    = st_q.thr;

    p_thr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> (st_q.locked && $stable(st_q.thr)));
    p_thr_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |-> (st_q.thr <= CEIL));
    p_no_lock_without_rails_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.locked) |-> $past(rails_ok));
endmodule

// File: rtl/lsw_trip_count.sv
module lsw_trip_count #(
    parameter int unsigned MV_W   = 10,
    parameter int unsigned TRIP_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            armed,
    input  logic            ls_end,
    input  logic [MV_W-1:0] sense_mv,
    input  logic [MV_W-1:0] thr,
    output logic            fault
);
    localparam int unsigned CNT_W = $clog2(TRIP_N + 1);
    localparam logic [CNT_W-1:0] TRIP = CNT_W'(TRIP_N);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } st_t;

    st_t  st_d, st_q;
    logic over;

    assign over = sense_mv > thr;

    always_comb begin
        st_d = st_q;
        if (!armed) begin
            st_d.cnt = '0;
        end else if (ls_end && !st_q.fault) begin
            if (!over) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != TRIP) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (over && st_q.cnt == TRIP - 1'b1) st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault = st_q.fault;

    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TRIP);
    p_clean_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ls_end && !over && !st_q.fault) |=> (st_q.cnt == '0));
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fault |=> st_q.fault);
    p_fault_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fault) |-> $past(ls_end && armed && over));
    p_disarm_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (st_q.cnt == '0));
endmodule

// File: rtl/lsw_ocp_guard.sv
module lsw_ocp_guard #(
    parameter int unsigned MV_W    = lsw_ocp_pkg::MV_W_DEF,
    parameter int unsigned CEIL_MV = lsw_ocp_pkg::CEIL_MV_DEF,
    parameter int unsigned TRIP_N  = lsw_ocp_pkg::TRIP_N_DEF,
    parameter int unsigned WIN_CYC = lsw_ocp_pkg::WIN_CYC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rails_ok,
    input  logic            reg_en,
    input  logic            prog_valid,
    input  logic [MV_W-1:0] prog_mv,
    input  logic            ls_end,
    input  logic [MV_W-1:0] sense_mv,
    input  logic            hs_req,
    input  logic            ls_req,
    output logic            hs_en,
    output logic            ls_en,
    output logic            fault,
    output logic            thr_locked,
    output logic [MV_W-1:0] thr_mv
);
    logic permit;

    lsw_thr_lock #(.MV_W(MV_W), .CEIL_MV(CEIL_MV), .WIN_CYC(WIN_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .rails_ok(rails_ok),
        .prog_valid(prog_valid), .prog_mv(prog_mv),
        .locked(thr_locked), .thr(thr_mv)
    );

    lsw_trip_count #(.MV_W(MV_W), .TRIP_N(TRIP_N)) u_count (
        .clk(clk), .rst_n(rst_n), .armed(thr_locked && reg_en),
        .ls_end(ls_end), .sense_mv(sense_mv), .thr(thr_mv),
        .fault(fault)
    );

    assign permit = thr_locked && reg_en && !fault;
    assign hs_en  = hs_req && permit;
    assign ls_en  = ls_req && permit;

    p_gates_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!hs_en && !ls_en));
    p_no_gate_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_locked |-> (!hs_en && !ls_en));
endmodule

// File: tb/lsw_ocp_guard_bench.sv
module lsw_ocp_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MV_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rails_ok = 1'b0, reg_en = 1'b0, prog_valid = 1'b0, ls_end = 1'b0;
    logic hs_req = 1'b0, ls_req = 1'b0;
    logic [MV_W-1:0] prog_mv = '0, sense_mv = '0;
    logic hs_en, ls_en, fault, thr_locked;
    logic [MV_W-1:0] thr_mv;
    int n_run = 0, n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsw_ocp_guard u_lsw_ocp_guard (
        .clk(clk), .rst_n(rst_n), .rails_ok(rails_ok), .reg_en(reg_en),
        .prog_valid(prog_valid), .prog_mv(prog_mv), .ls_end(ls_end),
        .sense_mv(sense_mv), .hs_req(hs_req), .ls_req(ls_req),
        .hs_en(hs_en), .ls_en(ls_en), .fault(fault),
        .thr_locked(thr_locked), .thr_mv(thr_mv)
    );

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rails_ok = 1'b0; reg_en = 1'b0; prog_valid = 1'b0;
        ls_end = 1'b0; hs_req = 1'b0; ls_req = 1'b0; sense_mv = '0; prog_mv = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic program_thr(int mv);
        rails_ok = 1'b1;
        prog_mv = MV_W'(mv); prog_valid = 1'b1;
        @(negedge clk);
        prog_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe(int mv);
        sense_mv = MV_W'(mv); ls_end = 1'b1;
        @(negedge clk);
        ls_end = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        hs_req = 1'b1; ls_req = 1'b1; reg_en = 1'b1;
        #1;
        check("R1 fault", fault, 0);
        check("R1 locked", thr_locked, 0);
        check("R1 thr", thr_mv, 0);
        check("R9 hs_en unlocked", hs_en, 0);
        check("R9 ls_en unlocked", ls_en, 0);
    endtask

    task automatic t_program_capture();
        do_reset();
        prog_mv = 300; prog_valid = 1'b1;
        @(negedge clk); prog_valid = 1'b0; @(negedge clk);
        check("R10 no lock without rails", thr_locked, 0);
        program_thr(200);
        check("R2 locked", thr_locked, 1);
        check("R2 thr", thr_mv, 200);
        program_thr(100);
        check("R2 later sample ignored", thr_mv, 200);
        do_reset();
        program_thr(900);
        check("R2 clamp to 640", thr_mv, 640);
    endtask

    task automatic t_window_expiry();
        do_reset();
        rails_ok = 1'b1;
        repeat (60) @(negedge clk);
        check("R3 not locked before window end", thr_locked, 0);
        repeat (8) @(negedge clk);
        check("R3 locked on expiry", thr_locked, 1);
        check("R3 ceiling value", thr_mv, 640);
        program_thr(100);
        check("R3 late sample ignored", thr_mv, 640);
    endtask

    task automatic t_gates();
        do_reset();
        program_thr(200);
        reg_en = 1'b1; hs_req = 1'b1; ls_req = 1'b0; #1;
        check("R9 hs pass", hs_en, 1);
        check("R9 ls pass", ls_en, 0);
        hs_req = 1'b0; ls_req = 1'b1; #1;
        check("R9 ls pass", ls_en, 1);
        reg_en = 1'b0; #1;
        check("R9 ls off when disabled", ls_en, 0);
        reg_en = 1'b1;
    endtask

    task automatic t_compare_edge();
        do_reset();
        program_thr(200);
        reg_en = 1'b1;
        for (int i = 0; i < 6; i++) strobe(200);
        check("R5 equal not over", fault, 0);
        sense_mv = 500;
        repeat (10) @(negedge clk);
        check("R5 no strobe no count", fault, 0);
        for (int i = 0; i < 3; i++) strobe(201);
        check("R7 three over no fault", fault, 0);
        strobe(201);
        check("R7 fourth over faults", fault, 1);
    endtask

    task automatic t_fourth_edge_timing();
        do_reset();
        program_thr(100);
        reg_en = 1'b1;
        for (int i = 0; i < 3; i++) strobe(300);
        sense_mv = 300; ls_end = 1'b1;
        @(posedge clk); #1;
        check("R7 fault visible right after fourth edge", fault, 1);
        @(negedge clk); ls_end = 1'b0;
    endtask

    task automatic t_clean_restart();
        do_reset();
        program_thr(200);
        reg_en = 1'b1;
        for (int i = 0; i < 3; i++) strobe(400);
        strobe(150);
        for (int i = 0; i < 3; i++) strobe(400);
        check("R6 clean cycle restarts count", fault, 0);
        strobe(400);
        check("R6 four after restart faults", fault, 1);
    endtask

    task automatic t_disable();
        do_reset();
        program_thr(200);
        reg_en = 1'b1;
        for (int i = 0; i < 3; i++) strobe(400);
        reg_en = 1'b0;
        @(negedge clk);
        check("R4 thr kept while disabled", thr_mv, 200);
        for (int i = 0; i < 5; i++) strobe(400);
        check("R11 disabled strobes ignored", fault, 0);
        reg_en = 1'b1;
        strobe(400);
        check("R11 disable cleared count", fault, 0);
        check("R4 thr kept after enable", thr_mv, 200);
    endtask

    task automatic t_unlocked_strobes();
        do_reset();
        reg_en = 1'b1;
        for (int i = 0; i < 5; i++) strobe(900);
        check("R11 unlocked strobes ignored", fault, 0);
    endtask

    task automatic t_sticky();
        do_reset();
        program_thr(100);
        reg_en = 1'b1;
        for (int i = 0; i < 4; i++) strobe(300);
        check("R8 fault set", fault, 1);
        reg_en = 1'b0; @(negedge clk); reg_en = 1'b1;
        for (int i = 0; i < 3; i++) strobe(10);
        hs_req = 1'b1; ls_req = 1'b1; #1;
        check("R8 fault held", fault, 1);
        check("R8 hs_en off", hs_en, 0);
        check("R8 ls_en off", ls_en, 0);
        check("R4 thr kept through fault", thr_mv, 100);
        do_reset();
        check("R1 reset clears fault", fault, 0);
    endtask

    initial begin
        t_reset_state();
        t_program_capture();
        t_window_expiry();
        t_gates();
        t_compare_edge();
        t_fourth_edge_timing();
        t_clean_restart();
        t_disable();
        t_unlocked_strobes();
        t_sticky();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule